// File: doc/BRIEF.md
# Bus Address Watchpoint Unit

This block watches the stream of memory accesses leaving a memory arbiter and flags those that fall inside programmed address windows. It has four independent watchpoints. Each watchpoint holds an inclusive address window, a two-bit mask of access kinds (read, write) and a per-client enable mask. When an access matches, the watchpoint records what it saw and raises its pending bit. The pending bits feed a global enable mask and a single interrupt line.

Software programs the windows through a simple register port. When the interrupt arrives, it reads the index of the lowest pending watchpoint and then that watchpoint's capture registers. It clears the pending bit through the global acknowledge register. A watchpoint that has captured ignores further hits until software writes its own re-arm register. Acknowledging the interrupt and re-arming the capture are therefore separate steps.

Top module: `bus_watch_unit`

## Requirements
- R1: After a synchronous reset, all of the following are zero: every configuration register, every capture register, the global enable mask, the pending bits and `irq`. All watchpoints start armed.
- R2: Register address = {global (bit 6), watchpoint (bits 5:4), field (bits 3:0)}. The per-watchpoint fields are:
  - 0: window low address (32 bits).
  - 1: window high address (32 bits).
  - 2: kind mask (2 bits). Bit 0 enables reads and bit 1 enables writes.
  - 3: client mask (14 bits).
  
  These fields read back what was written, truncated to their widths.
- R3: An access matches a watchpoint under all of these conditions:
  - `acc_valid` is high.
  - low ≤ `acc_addr` ≤ high.
  - The kind-mask bit selected by `acc_write` (0 = read, 1 = write) is set.
  - `acc_client` is below 14 and its bit in the client mask is set.
  
  A client index of 14 or 15 never matches.
- R4: An armed watchpoint captures its first match at that clock edge and sets its pending bit at the same edge. The capture registers are readable at these fields:
  - 4: one-hot client bits.
  - 5: address.
  - 6: kind (0 read, 1 write).
  - 7: client index.
  - 8: size.
- R5: Once a watchpoint has captured, its capture registers hold through later matches. Writing its field 9 (re-arm, reads 0) arms it again, and the old capture stays readable until the next match. A match in the same cycle as the re-arm write is not captured.
- R6: Global register 0x40 is the 4-bit interrupt enable mask. 0x41 reads the pending bits ANDed with that mask. Clearing an enable bit does not clear the pending bit.
- R7: Writing 0x42 clears every pending bit whose write-data bit is 1. A capture in the same cycle as the acknowledge leaves that bit set.
- R8: `irq` is a register equal to the OR of the enabled pending bits. It rises at the same edge as the capture and falls at the edge of the acknowledge or mask write.
- R9: Several watchpoints matching the same access each capture independently. Register 0x43 reads bit 2 = any pending and bits 1:0 = lowest pending index, or 0 when nothing is pending.
- R10: `reg_rdata` is registered and reflects `reg_addr` one clock later. Unmapped addresses and write-only fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Monitored access present this cycle |
| acc_client | input | 4 | Requesting client index |
| acc_addr | input | 32 | Physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access size code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
A watchpoint stuck armed shows up as a changed capture register at the very next matching access, read one cycle later. A watchpoint stuck disarmed shows up as a missing pending bit in the masked status and `irq` after the first match following a re-arm. A pending bit left set, or cleared wrongly, appears on `irq` at the edge after the acknowledge or mask write. It also shows in the lowest-index register at the next read. A wrong window or mask comparison is caught by matches placed exactly on the window boundaries, one address beyond each boundary, and by client indices past the last valid client.

// File: rtl/bwu_pkg.sv
package bwu_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    F_LOW     = 4'd0,
    F_HIGH    = 4'd1,
    F_KINDS   = 4'd2,
    F_CLIENTS = 4'd3,
    F_CAP_CLI = 4'd4,
    F_CAP_ADR = 4'd5,
    F_CAP_KND = 4'd6,
    F_CAP_IDX = 4'd7,
    F_CAP_SZ  = 4'd8,
    F_REARM   = 4'd9
  } wp_field_e;

  typedef enum logic [FIELD_W-1:0] {
    G_ENABLE  = 4'd0,
    G_STATUS  = 4'd1,
    G_ACK     = 4'd2,
    G_LOWEST  = 4'd3
  } glb_field_e;
endpackage

// File: rtl/bwu_watchpoint.sv
module bwu_watchpoint
  import bwu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NCLI   = 14,
  parameter int CLI_W  = 4,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  wp_field_e         cfg_field,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [CLI_W-1:0]  acc_client,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  output logic [DATA_W-1:0] rd_data,
  output logic              cap_set
);
  logic [ADDR_W-1:0] low_q, high_q;
  logic [1:0]        kinds_q;
  logic [NCLI-1:0]   clients_q;

  logic              armed_q;
  logic [NCLI-1:0]   cap_cli_q;
  logic [ADDR_W-1:0] cap_adr_q;
  logic              cap_knd_q;
  logic [CLI_W-1:0]  cap_idx_q;
  logic [SIZE_W-1:0] cap_sz_q;

  logic [NCLI-1:0]   cli_onehot;
  logic              in_window, kind_ok, client_ok, match, rearm;

  always_comb begin
    cli_onehot = '0;
    if (32'(acc_client) < NCLI) cli_onehot = NCLI'(1) << acc_client;
  end

  assign in_window = (acc_addr >= low_q) && (acc_addr <= high_q);
  assign kind_ok   = kinds_q[acc_write];
  assign client_ok = |(cli_onehot & clients_q);
  assign match     = acc_valid && in_window && kind_ok && client_ok;
  assign rearm     = cfg_we && (cfg_field == F_REARM);
  assign cap_set   = armed_q && match && !rearm;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q     <= '0;
      high_q    <= '0;
      kinds_q   <= '0;
      clients_q <= '0;
    end else if (cfg_we) begin
      case (cfg_field)
        F_LOW:     low_q     <= cfg_wdata[ADDR_W-1:0];
        F_HIGH:    high_q    <= cfg_wdata[ADDR_W-1:0];
        F_KINDS:   kinds_q   <= cfg_wdata[1:0];
        F_CLIENTS: clients_q <= cfg_wdata[NCLI-1:0];
        default: ;
      endcase
    end
  end

  // capture state: re-arm has priority over a coincident match
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b1;
      cap_cli_q <= '0;
      cap_adr_q <= '0;
      cap_knd_q <= 1'b0;
      cap_idx_q <= '0;
      cap_sz_q  <= '0;
    end else if (rearm) begin
      armed_q   <= 1'b1;
    end else if (cap_set) begin
      armed_q   <= 1'b0;
      cap_cli_q <= cli_onehot;
      cap_adr_q <= acc_addr;
      cap_knd_q <= acc_write;
      cap_idx_q <= acc_client;
      cap_sz_q  <= acc_size;
    end
  end

  always_comb begin
    case (cfg_field)
      F_LOW:     rd_data = DATA_W'(low_q);
      F_HIGH:    rd_data = DATA_W'(high_q);
      F_KINDS:   rd_data = DATA_W'(kinds_q);
      F_CLIENTS: rd_data = DATA_W'(clients_q);
      F_CAP_CLI: rd_data = DATA_W'(cap_cli_q);
      F_CAP_ADR: rd_data = DATA_W'(cap_adr_q);
      F_CAP_KND: rd_data = DATA_W'(cap_knd_q);
      F_CAP_IDX: rd_data = DATA_W'(cap_idx_q);
      F_CAP_SZ:  rd_data = DATA_W'(cap_sz_q);
      default:   rd_data = '0;
    endcase
  end

  AST_CAPTURE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (armed_q && match && !rearm) |=> (!armed_q && cap_adr_q == $past(acc_addr))); // R4
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !rearm) |=> (!armed_q && $stable(cap_adr_q) && $stable(cap_idx_q) && $stable(cap_sz_q))); // R5
  AST_REARM_ARMS: assert property (@(posedge clk) disable iff (rst)
    rearm |=> armed_q); // R5
  AST_NO_BAD_CLIENT: assert property (@(posedge clk) disable iff (rst)
    (32'(acc_client) >= NCLI) |-> !match); // R3
endmodule

// File: rtl/bwu_irq_ctrl.sv
module bwu_irq_ctrl #(
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_WP-1:0] cap_set,
  input  logic              enable_we,
  input  logic              ack_we,
  input  logic [NUM_WP-1:0] wdata,
  output logic [NUM_WP-1:0] enable_q,
  output logic [NUM_WP-1:0] pend_q,
  output logic [IDX_W-1:0]  low_idx,
  output logic              low_valid,
  output logic              irq
);
  logic [NUM_WP-1:0] pend_nxt, enable_nxt, ack_bits;

  assign ack_bits   = ack_we ? wdata : '0;
  assign pend_nxt   = (pend_q & ~ack_bits) | cap_set;
  assign enable_nxt = enable_we ? wdata : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      enable_q <= '0;
      irq      <= 1'b0;
    end else begin
      pend_q   <= pend_nxt;
      enable_q <= enable_nxt;
      irq      <= |(pend_nxt & enable_nxt);
    end
  end

  always_comb begin
    low_valid = 1'b0;
    low_idx   = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        low_valid = 1'b1;
        low_idx   = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_bit_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      cap_set[g] |=> pend_q[g]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ack_we && wdata[g] && !cap_set[g]) |=> !pend_q[g]); // R7
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend_q & enable_q)); // R8
  AST_LOWEST_PENDING: assert property (@(posedge clk) disable iff (rst)
    low_valid |-> pend_q[low_idx]); // R9
endmodule

// File: rtl/bwu_reg_if.sv
module bwu_reg_if
  import bwu_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  parameter int REG_AW = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [NUM_WP-1:0][DATA_W-1:0] wp_rd,
  input  logic [NUM_WP-1:0]             enable_q,
  input  logic [NUM_WP-1:0]             pend_q,
  input  logic [IDX_W-1:0]              low_idx,
  input  logic                          low_valid,
  output wp_field_e                     wp_field,
  output logic [NUM_WP-1:0]             wp_we,
  output logic                          enable_we,
  output logic                          ack_we,
  output logic [DATA_W-1:0]             reg_rdata
);
  logic              is_glb;
  logic [IDX_W-1:0]  wsel;
  glb_field_e        gfield;
  logic [DATA_W-1:0] rd_nxt;

  assign is_glb   = reg_addr[REG_AW-1];
  assign wsel     = reg_addr[FIELD_W +: IDX_W];
  assign wp_field = wp_field_e'(reg_addr[FIELD_W-1:0]);
  assign gfield   = glb_field_e'(reg_addr[FIELD_W-1:0]);

  for (genvar g = 0; g < NUM_WP; g++) begin : g_we
    assign wp_we[g] = reg_wr && !is_glb && (wsel == IDX_W'(g));
  end

  assign enable_we = reg_wr && is_glb && (gfield == G_ENABLE);
  assign ack_we    = reg_wr && is_glb && (gfield == G_ACK);

  always_comb begin
    rd_nxt = '0;
    if (!is_glb) begin
      rd_nxt = wp_rd[wsel];
    end else begin
      case (gfield)
        G_ENABLE: rd_nxt = DATA_W'(enable_q);
        G_STATUS: rd_nxt = DATA_W'(pend_q & enable_q);
        G_LOWEST: rd_nxt = low_valid ? DATA_W'({1'b1, low_idx}) : '0;
        default:  rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wp_we, enable_we, ack_we})); // R2
endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
  import bwu_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NCLI   = 14,
  parameter int SIZE_W = 3,
  localparam int CLI_W  = $clog2(NCLI),
  localparam int IDX_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int REG_AW = 1 + IDX_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [CLI_W-1:0]  acc_client,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  wp_field_e                     wp_field;
  logic [NUM_WP-1:0]             wp_we;
  logic [NUM_WP-1:0][DATA_W-1:0] wp_rd;
  logic [NUM_WP-1:0]             cap_set;
  logic [NUM_WP-1:0]             enable_q, pend_q;
  logic [IDX_W-1:0]              low_idx;
  logic                          low_valid, enable_we, ack_we;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    bwu_watchpoint #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCLI(NCLI),
      .CLI_W(CLI_W), .SIZE_W(SIZE_W)
    ) u_wp (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (wp_we[g]),
      .cfg_field (wp_field),
      .cfg_wdata (reg_wdata),
      .acc_valid (acc_valid),
      .acc_client(acc_client),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .acc_size  (acc_size),
      .rd_data   (wp_rd[g]),
      .cap_set   (cap_set[g])
    );
  end

  bwu_irq_ctrl #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cap_set  (cap_set),
    .enable_we(enable_we),
    .ack_we   (ack_we),
    .wdata    (reg_wdata[NUM_WP-1:0]),
    .enable_q (enable_q),
    .pend_q   (pend_q),
    .low_idx  (low_idx),
    .low_valid(low_valid),
    .irq      (irq)
  );

  bwu_reg_if #(
    .NUM_WP(NUM_WP), .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wp_rd    (wp_rd),
    .enable_q (enable_q),
    .pend_q   (pend_q),
    .low_idx  (low_idx),
    .low_valid(low_valid),
    .wp_field (wp_field),
    .wp_we    (wp_we),
    .enable_we(enable_we),
    .ack_we   (ack_we),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/bus_watch_unit_test.sv
module bus_watch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_client = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_size = '0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model
  logic [31:0] m_low [4];
  logic [31:0] m_high[4];
  logic [1:0]  m_kinds[4];
  logic [13:0] m_cli [4];
  logic        m_armed[4];
  logic [13:0] m_ccli[4];
  logic [31:0] m_cadr[4];
  logic        m_cknd[4];
  logic [3:0]  m_cidx[4];
  logic [2:0]  m_csz [4];
  logic [3:0]  m_en;
  logic [3:0]  m_pend;

  bus_watch_unit uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_client(acc_client),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_size(acc_size),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic bit f_hit(int w, int cli, logic [31:0] a, bit wr);
    if (cli >= 14) return 1'b0;
    return (a >= m_low[w]) && (a <= m_high[w]) && m_kinds[w][wr] && m_cli[w][cli];
  endfunction

  function automatic logic [31:0] exp_rd(logic [6:0] a);
    int w = int'(a[5:4]);
    int f = int'(a[3:0]);
    if (a[6]) begin
      case (f)
        0: return {28'd0, m_en};
        1: return {28'd0, m_pend & m_en};
        3: begin
          for (int i = 0; i < 4; i++) if (m_pend[i]) return 32'(4 + i);
          return 32'd0;
        end
        default: return 32'd0;
      endcase
    end
    case (f)
      0: return m_low[w];
      1: return m_high[w];
      2: return {30'd0, m_kinds[w]};
      3: return {18'd0, m_cli[w]};
      4: return {18'd0, m_ccli[w]};
      5: return m_cadr[w];
      6: return {31'd0, m_cknd[w]};
      7: return {28'd0, m_cidx[w]};
      8: return {29'd0, m_csz[w]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 4; w++) begin
      m_low[w] = '0; m_high[w] = '0; m_kinds[w] = '0; m_cli[w] = '0;
      m_armed[w] = 1'b1; m_ccli[w] = '0; m_cadr[w] = '0; m_cknd[w] = 1'b0;
      m_cidx[w] = '0; m_csz[w] = '0;
    end
    m_en = '0; m_pend = '0;
  endtask

  task automatic cyc(bit da, int cli, logic [31:0] a, bit wr, logic [2:0] sz,
                     bit dr, logic [6:0] ra, logic [31:0] wd);
    logic [3:0] caps;
    @(negedge clk);
    acc_valid = da; acc_client = cli[3:0]; acc_addr = a; acc_write = wr; acc_size = sz;
    reg_wr = dr; reg_addr = ra; reg_wdata = wd;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; reg_wr = 1'b0;
    caps = '0;
    for (int w = 0; w < 4; w++) begin
      bit rearm = dr && (ra == 7'(w * 16 + 9));
      if (rearm) m_armed[w] = 1'b1;
      else if (da && m_armed[w] && f_hit(w, cli, a, wr)) begin
        caps[w] = 1'b1; m_armed[w] = 1'b0;
        m_ccli[w] = 14'd1 << cli; m_cadr[w] = a; m_cknd[w] = wr;
        m_cidx[w] = cli[3:0]; m_csz[w] = sz;
      end
    end
    if (dr && !ra[6]) begin
      case (int'(ra[3:0]))
        0: m_low[ra[5:4]]   = wd;
        1: m_high[ra[5:4]]  = wd;
        2: m_kinds[ra[5:4]] = wd[1:0];
        3: m_cli[ra[5:4]]   = wd[13:0];
        default: ;
      endcase
    end
    if (dr && ra == 7'h40) m_en = wd[3:0];
    if (dr && ra == 7'h42) m_pend = m_pend & ~wd[3:0];
    m_pend = m_pend | caps;
  endtask

  task automatic wr_reg(logic [6:0] ra, logic [31:0] wd);
    cyc(1'b0, 0, 32'd0, 1'b0, 3'd0, 1'b1, ra, wd);
  endtask

  task automatic acc(int cli, logic [31:0] a, bit wr, logic [2:0] sz);
    cyc(1'b1, cli, a, wr, sz, 1'b0, 7'd0, 32'd0);
  endtask

  task automatic rd(logic [6:0] a, string tag);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0; acc_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check($sformatf("%s addr %h", tag, a), reg_rdata, exp_rd(a));
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, |(m_pend & m_en)});
  endtask

  task automatic chk_all(string tag);
    for (int w = 0; w < 4; w++)
      for (int f = 0; f < 10; f++) rd(7'(w * 16 + f), tag);
    for (int f = 0; f < 5; f++) rd(7'(64 + f), tag);
  endtask

  task automatic cfg_wp(int w, logic [31:0] lo, logic [31:0] hi, logic [1:0] k, logic [13:0] c);
    wr_reg(7'(w * 16 + 0), lo);
    wr_reg(7'(w * 16 + 1), hi);
    wr_reg(7'(w * 16 + 2), {30'd0, k});
    wr_reg(7'(w * 16 + 3), {18'd0, c});
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk_irq("R1 irq after reset");
    chk_all("R1 reset readback");

    // R2: config readback with truncation
    cfg_wp(0, 32'h100, 32'h1FF, 2'b11, 14'h0004);
    wr_reg(7'h12, 32'hFFFF_FFFF);
    wr_reg(7'h13, 32'hFFFF_FFFF);
    rd(7'h00, "R2 low");  rd(7'h01, "R2 high");
    rd(7'h12, "R2 kinds truncated"); rd(7'h13, "R2 clients truncated");
    wr_reg(7'h40, 32'hF);
    rd(7'h40, "R6 enable readback");

    // R3: non-matching accesses
    acc(2, 32'hFF, 1'b0, 3'd1);  rd(7'h41, "R3 below window");
    acc(2, 32'h200, 1'b0, 3'd1); rd(7'h41, "R3 above window");
    acc(3, 32'h150, 1'b0, 3'd1); rd(7'h41, "R3 client masked");
    wr_reg(7'h02, 32'h1);
    acc(2, 32'h150, 1'b1, 3'd1); rd(7'h41, "R3 kind masked");
    cfg_wp(1, 32'h0, 32'hFFFF_FFFF, 2'b11, 14'h3FFF);
    acc(14, 32'h10, 1'b0, 3'd0); rd(7'h41, "R3 client 14 ignored");
    acc(15, 32'h10, 1'b1, 3'd0); rd(7'h41, "R3 client 15 ignored");
    wr_reg(7'h11, 32'h0);
    wr_reg(7'h10, 32'h1);

    // R4, R8: hit exactly on the high bound
    acc(2, 32'h1FF, 1'b0, 3'd5);
    chk_irq("R8 irq on capture");
    rd(7'h04, "R4 cap clients"); rd(7'h05, "R4 cap addr");
    rd(7'h06, "R4 cap kind");    rd(7'h07, "R4 cap index");
    rd(7'h08, "R4 cap size");    rd(7'h41, "R4 pending");
    rd(7'h43, "R9 lowest single");

    // R5: hold through later hits
    wr_reg(7'h02, 32'h3);
    acc(2, 32'h100, 1'b1, 3'd2);
    rd(7'h05, "R5 addr held"); rd(7'h08, "R5 size held");

    // R7: ack clears pending, irq drops
    wr_reg(7'h42, 32'h1);
    chk_irq("R7 irq after ack");
    rd(7'h41, "R7 status after ack");
    acc(2, 32'h100, 1'b1, 3'd2);
    rd(7'h41, "R5 not rearmed, no pending");
    wr_reg(7'h09, 32'h0);
    rd(7'h05, "R5 capture kept after rearm");
    rd(7'h09, "R10 rearm field reads zero");
    acc(2, 32'h100, 1'b1, 3'd2);
    rd(7'h05, "R5 new capture low bound");
    rd(7'h06, "R5 new capture kind");

    // R6, R8: enable mask hides but keeps pending
    wr_reg(7'h40, 32'hE);
    chk_irq("R8 irq masked");
    rd(7'h41, "R6 masked status");
    wr_reg(7'h40, 32'hF);
    chk_irq("R6 irq restored");
    rd(7'h41, "R6 pending retained");
    wr_reg(7'h42, 32'h1);

    // R9: simultaneous hits
    for (int w = 1; w < 4; w++) cfg_wp(w, 32'h400, 32'h4FF, 2'b10, 14'h3FFF);
    acc(7, 32'h480, 1'b1, 3'd3);
    rd(7'h41, "R9 three pending");
    rd(7'h43, "R9 lowest index 1");
    rd(7'h25, "R9 wp2 capture"); rd(7'h37, "R9 wp3 capture");
    wr_reg(7'h42, 32'h2);
    rd(7'h43, "R9 lowest index 2");

    // R5: rearm coinciding with a hit does not capture
    cyc(1'b1, 9, 32'h4F0, 1'b1, 3'd6, 1'b1, 7'h19, 32'h0);
    rd(7'h41, "R5 rearm+hit no pending");
    rd(7'h15, "R5 rearm+hit addr kept");
    acc(9, 32'h4F0, 1'b1, 3'd6);
    rd(7'h15, "R5 capture after rearm");

    // R7: capture wins over same-cycle ack
    wr_reg(7'h42, 32'h4);
    wr_reg(7'h29, 32'h0);
    cyc(1'b1, 0, 32'h400, 1'b1, 3'd1, 1'b1, 7'h42, 32'h4);
    rd(7'h41, "R7 set wins over ack");
    chk_irq("R8 irq after set-vs-ack");

    // R10: unmapped reads
    rd(7'h4A, "R10 unmapped global");
    rd(7'h3F, "R10 unmapped field");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 10);
      int w = int'($urandom % 4);
      if (r == 0) begin
        logic [31:0] lo = $urandom % 256;
        cfg_wp(w, lo, lo + ($urandom % 64), 2'($urandom), 14'($urandom));
      end else if (r == 1) wr_reg(7'(w * 16 + 9), 32'h0);
      else if (r == 2) wr_reg(7'h42, $urandom % 16);
      else if (r == 3) wr_reg(7'h40, $urandom % 16);
      else acc(int'($urandom % 16), $urandom % 320, 1'($urandom), 3'($urandom));
      chk_irq("R8 random irq");
      if (it % 40 == 39) chk_all("R4 random readback");
    end

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule